// File: doc/BRIEF.md
# Frequency Lock Detector with Reference Fallback

This block decides whether a recovered bit clock runs close enough to the rate implied by a local reference clock. It works on a single system clock and receives one-cycle strobes marking edges of the reference clock and of the recovered clock. It counts recovered strobes over a window of reference strobes and compares the count with the count that the selected divide ratio predicts. The tolerance is roughly one part in a thousand.

Its outputs steer a clock-recovery loop. When the block is locked, the loop tracks incoming data. When it is not locked, the loop trains on the reference, and every fourth window the loop is handed to data so that the block can test whether data is usable again. A carrier-detect input overrides everything else. While carrier is absent, the lock flag is low, recovered data is gated to zero and the loop stays on the reference.

Top module: `freq_lock_monitor`

## Requirements
- R1: `ratio_sel_i` selects the expected ratio of recovered to reference rate: 00 gives 8, 01 gives 10, 10 gives 16, 11 gives 20. A window spans 2^WIN_LOG2 reference strobes, and its expected recovered count is that length times the ratio.
- R2: A window passes when the absolute difference between the recovered-strobe count and the expected count is no more than the expected count shifted right by TOL_SHIFT. Recovered strobes in the same cycle as the last reference strobe of a window belong to that window.
- R3: While locked, one failing window leaves `lock_o` high. A second failing window right after it drops `lock_o` and `follow_data_o`. A passing window clears the run of failures.
- R4: While unlocked, the block counts windows from the moment it became unlocked. `follow_data_o` is high only during every fourth window (the probe window) and low during the other three.
- R5: While unlocked, two probe windows in a row that pass raise `lock_o`. A probe that fails clears the run of passes. Results of non-probe windows have no effect on lock.
- R6: `lock_o` high always comes with `follow_data_o` high and `data_en_o` high.
- R7: When carrier is low, `lock_o`, `follow_data_o` and `data_en_o` go low within three clock edges. When carrier is high, `data_en_o` is high.
- R8: `carrier_i` passes through a two-flop synchronizer. While the synchronized carrier is low, the measurement is held cleared. After it rises, the first window starts with the first reference strobe.
- R9: After synchronous reset, the block is unlocked and follows the reference, with `lock_o`, `follow_data_o` and `data_en_o` low and the window count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | One-cycle strobe per reference clock edge |
| rec_tick_i | input | 1 | One-cycle strobe per recovered clock edge |
| carrier_i | input | 1 | Carrier present, asynchronous |
| ratio_sel_i | input | 2 | Expected ratio select (8, 10, 16, 20) |
| lock_o | output | 1 | Frequency lock, active high |
| follow_data_o | output | 1 | 1: loop follows data, 0: loop trains on reference |
| data_en_o | output | 1 | 0 forces recovered data low |

## Verification
All four ratio codes are swept, and each acquires lock from reset. The windows between probes carry a count far off target, which shows that only probe windows decide reacquisition. Once locked, the bench sends counts exactly at the tolerance edge and one beyond it on either side. This separates an off-by-one tolerance, a single-miss unlock, and a failure run that is never cleared. For one ratio a failing probe is placed between passing ones, which shows that the pass run resets. Carrier is dropped partway through a window and then restored. The exact acquisition that follows exposes any window left misaligned after the restart.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  typedef enum logic [1:0] {
    SEL_X8  = 2'b00,
    SEL_X10 = 2'b01,
    SEL_X16 = 2'b10,
    SEL_X20 = 2'b11
  } ratio_sel_t;

  typedef enum logic {
    ST_TRAIN = 1'b0,
    ST_LOCK  = 1'b1
  } lock_state_t;

  localparam int RATIO_W = 5;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] sel);
    case (ratio_sel_t'(sel))
      SEL_X8:  ratio_of = 5'd8;
      SEL_X10: ratio_of = 5'd10;
      SEL_X16: ratio_of = 5'd16;
      default: ratio_of = 5'd20;
    endcase
  endfunction

endpackage

// File: rtl/lkd_sync.sv
module lkd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lkd_window_meter.sv
module lkd_window_meter
  import lkd_pkg::*;
#(
  parameter int WIN_LOG2  = 10,
  parameter int TOL_SHIFT = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_i,
  input  logic       ref_tick_i,
  input  logic       rec_tick_i,
  input  logic [1:0] ratio_sel_i,
  output logic       win_vld_o,
  output logic       win_pass_o
);
  localparam int CNT_W = WIN_LOG2 + 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [WIN_LOG2-1:0] REF_LAST = '1;

  logic [WIN_LOG2-1:0] ref_cnt;
  logic [CNT_W-1:0]    rec_cnt, rec_next;
  logic [CNT_W-1:0]    cap_cnt, cap_exp;
  logic                cap_vld;
  logic [CNT_W-1:0]    diff, tol;

  // saturating increment keeps a runaway clock from wrapping into range
  always_comb begin
    rec_next = rec_cnt;
    if (rec_tick_i && rec_cnt != CNT_MAX) rec_next = rec_cnt + 1'b1;
  end

  always_comb begin
    diff = (cap_cnt >= cap_exp) ? (cap_cnt - cap_exp) : (cap_exp - cap_cnt);
    tol  = cap_exp >> TOL_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      ref_cnt    <= '0;
      rec_cnt    <= '0;
      cap_cnt    <= '0;
      cap_exp    <= '0;
      cap_vld    <= 1'b0;
      win_vld_o  <= 1'b0;
      win_pass_o <= 1'b0;
    end else begin
      cap_vld   <= 1'b0;
      win_vld_o <= cap_vld;
      if (ref_tick_i && ref_cnt == REF_LAST) begin
        cap_cnt <= rec_next;
        cap_exp <= CNT_W'(ratio_of(ratio_sel_i)) << WIN_LOG2;
        cap_vld <= 1'b1;
        ref_cnt <= '0;
        rec_cnt <= '0;
      end else begin
        if (ref_tick_i) ref_cnt <= ref_cnt + 1'b1;
        rec_cnt <= rec_next;
      end
      if (cap_vld) win_pass_o <= (diff <= tol);
    end
  end
endmodule

// File: rtl/lkd_lock_fsm.sv
module lkd_lock_fsm
  import lkd_pkg::*;
#(
  parameter int POLL_LEN = 4,
  parameter int CONFIRM  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cd_ok_i,
  input  logic win_vld_i,
  input  logic win_pass_i,
  output logic lock_o,
  output logic follow_data_o,
  output logic data_en_o
);
  localparam int PH_W = (POLL_LEN > 1) ? $clog2(POLL_LEN) : 1;
  localparam int DC_W = (CONFIRM > 1) ? $clog2(CONFIRM) : 1;
  localparam logic [PH_W-1:0] PH_PROBE = PH_W'(POLL_LEN - 1);
  localparam logic [DC_W-1:0] DC_LAST  = DC_W'(CONFIRM - 1);

  lock_state_t     state, state_n;
  logic [PH_W-1:0] phase, phase_n;
  logic [DC_W-1:0] run,   run_n;

  always_comb begin
    state_n = state;
    phase_n = phase;
    run_n   = run;
    if (!cd_ok_i) begin
      state_n = ST_TRAIN;
      phase_n = '0;
      run_n   = '0;
    end else if (win_vld_i) begin
      if (state == ST_LOCK) begin
        if (win_pass_i) run_n = '0;
        else if (run == DC_LAST) begin
          state_n = ST_TRAIN;
          phase_n = '0;
          run_n   = '0;
        end else run_n = run + 1'b1;
      end else if (phase == PH_PROBE) begin
        phase_n = '0;
        if (!win_pass_i) run_n = '0;
        else if (run == DC_LAST) begin
          state_n = ST_LOCK;
          run_n   = '0;
        end else run_n = run + 1'b1;
      end else begin
        phase_n = phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_TRAIN;
      phase         <= '0;
      run           <= '0;
      lock_o        <= 1'b0;
      follow_data_o <= 1'b0;
      data_en_o     <= 1'b0;
    end else begin
      state         <= state_n;
      phase         <= phase_n;
      run           <= run_n;
      lock_o        <= cd_ok_i && state_n == ST_LOCK;
      follow_data_o <= cd_ok_i && (state_n == ST_LOCK || phase_n == PH_PROBE);
      data_en_o     <= cd_ok_i;
    end
  end
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
  import lkd_pkg::*;
#(
  parameter int WIN_LOG2    = 10,
  parameter int TOL_SHIFT   = 10,
  parameter int POLL_LEN    = 4,
  parameter int CONFIRM     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_tick_i,
  input  logic       rec_tick_i,
  input  logic       carrier_i,
  input  logic [1:0] ratio_sel_i,
  output logic       lock_o,
  output logic       follow_data_o,
  output logic       data_en_o
);
  logic cd_sync;
  logic win_vld, win_pass;

  lkd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (carrier_i),
    .q_o (cd_sync)
  );

  lkd_window_meter #(.WIN_LOG2(WIN_LOG2), .TOL_SHIFT(TOL_SHIFT)) u_meter (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (!cd_sync),
    .ref_tick_i  (ref_tick_i),
    .rec_tick_i  (rec_tick_i),
    .ratio_sel_i (ratio_sel_i),
    .win_vld_o   (win_vld),
    .win_pass_o  (win_pass)
  );

  lkd_lock_fsm #(.POLL_LEN(POLL_LEN), .CONFIRM(CONFIRM)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .cd_ok_i       (cd_sync),
    .win_vld_i     (win_vld),
    .win_pass_i    (win_pass),
    .lock_o        (lock_o),
    .follow_data_o (follow_data_o),
    .data_en_o     (data_en_o)
  );
endmodule

// File: rtl/lkd_checker.sv
module lkd_checker (
  input logic clk,
  input logic rst,
  input logic cd_sync,
  input logic win_vld,
  input logic win_pass,
  input logic lock_o,
  input logic follow_data_o,
  input logic data_en_o
);
  p_lock_follows_r6: assert property (@(posedge clk) disable iff (rst)
    lock_o |-> (follow_data_o && data_en_o));

  p_cd_low_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cd_sync |=> (!lock_o && !follow_data_o && !data_en_o));

  p_cd_high_enable_r7: assert property (@(posedge clk) disable iff (rst)
    cd_sync |=> data_en_o);

  p_lock_rise_on_pass_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(win_vld && win_pass));

  p_lock_fall_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> ($past(!cd_sync) || $past(win_vld && !win_pass)));

  p_result_needs_carrier_r8: assert property (@(posedge clk) disable iff (rst)
    !cd_sync |=> !win_vld);
endmodule

bind freq_lock_monitor lkd_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .cd_sync       (cd_sync),
  .win_vld       (win_vld),
  .win_pass      (win_pass),
  .lock_o        (lock_o),
  .follow_data_o (follow_data_o),
  .data_en_o     (data_en_o)
);

// File: tb/tb_freq_lock_monitor.sv
module tb_freq_lock_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_LOG2   = 6;
  localparam int TOL_SHIFT  = 6;
  localparam int NREF       = 1 << WIN_LOG2;
  localparam int SLOT       = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0, rec_tick = 1'b0, carrier = 1'b0;
  logic [1:0] sel = 2'b00;
  logic lock, follow, den;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  bit m_lock; int m_phase; int m_run; bit m_cd;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_lock_monitor #(.WIN_LOG2(WIN_LOG2), .TOL_SHIFT(TOL_SHIFT)) dut (
    .clk(clk), .rst(rst), .ref_tick_i(ref_tick), .rec_tick_i(rec_tick),
    .carrier_i(carrier), .ratio_sel_i(sel),
    .lock_o(lock), .follow_data_o(follow), .data_en_o(den));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio(input logic [1:0] s);
    case (s) 2'b00: return 8; 2'b01: return 10; 2'b10: return 16; default: return 20; endcase
  endfunction

  function automatic int exp_cnt();
    return ratio(sel) * NREF;
  endfunction

  function automatic int tol_cnt();
    return exp_cnt() >> TOL_SHIFT;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b0; rec_tick = 1'b0;
    end
  endtask

  task automatic tick_block(input int cnt, input int nref);
    int total;
    total = nref * SLOT;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      ref_tick = ((i % SLOT) == SLOT - 1);
      rec_tick = (((i + 1) * cnt) / total) != ((i * cnt) / total);
    end
    idle(1);
  endtask

  task automatic model_window(input int cnt);
    int d; bit pass;
    d = (cnt > exp_cnt()) ? cnt - exp_cnt() : exp_cnt() - cnt;
    pass = (d <= tol_cnt());
    if (!m_cd) return;
    if (m_lock) begin
      if (pass) m_run = 0;
      else if (m_run == 1) begin m_lock = 0; m_phase = 0; m_run = 0; end
      else m_run++;
    end else if (m_phase == 3) begin
      m_phase = 0;
      if (!pass) m_run = 0;
      else if (m_run == 1) begin m_lock = 1; m_run = 0; end
      else m_run++;
    end else m_phase++;
  endtask

  task automatic window(input int cnt, input string req);
    tick_block(cnt, NREF);
    idle(4);
    model_window(cnt);
    chk({req, " lock"}, lock, m_lock);
    chk({req, " follow"}, follow, (m_lock || m_phase == 3) ? 1 : 0);
    chk({req, " data_en R7"}, den, m_cd);
  endtask

  task automatic do_reset();
    rst = 1'b1; carrier = 1'b0;
    idle(5);
    chk("R9 lock after reset", lock, 0);
    chk("R9 follow after reset", follow, 0);
    chk("R9 data_en after reset", den, 0);
    rst = 1'b0; carrier = 1'b1;
    idle(8);
    m_lock = 0; m_phase = 0; m_run = 0; m_cd = 1;
    chk("R7 data_en with carrier", den, 1);
    chk("R4 follow idle", follow, 0);
  endtask

  // acquisition: junk on non-probe windows, exact count on probes
  task automatic acquire(input string req);
    for (int w = 0; w < 8; w++) begin
      if (w % 4 == 3) window(exp_cnt(), req);
      else            window(exp_cnt() / 2, "R5 ignored junk");
    end
    chk({req, " locked"}, lock, 1);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0];
      do_reset();
      if (s == 3) begin
        for (int w = 0; w < 3; w++) window(exp_cnt() / 2, "R5 ignored junk");
        chk("R4 probe follow", follow, 1);
        window(exp_cnt(), "R5 probe pass");
        for (int w = 0; w < 3; w++) window(exp_cnt() + 200, "R5 ignored junk");
        window(exp_cnt() + tol_cnt() + 1, "R5 probe fail clears run");
        chk("R5 still unlocked", lock, 0);
      end
      acquire("R1 R5 acquire");
      window(exp_cnt() + tol_cnt(), "R2 upper edge pass");
      window(exp_cnt() + tol_cnt() + 1, "R3 single miss holds");
      chk("R3 held lock", lock, 1);
      window(exp_cnt(), "R3 pass clears misses");
      window(exp_cnt() - tol_cnt() - 1, "R2 lower edge fail");
      window(exp_cnt() + tol_cnt() + 1, "R3 second miss unlocks");
      chk("R3 unlocked", lock, 0);
      chk("R6 follow drops", follow, 0);
      if (s == 0) begin
        acquire("R5 reacquire");
        carrier = 1'b0;
        tick_block(exp_cnt() / 3, 29);
        idle(2);
        m_cd = 0; m_lock = 0; m_phase = 0; m_run = 0;
        chk("R7 lock forced low", lock, 0);
        chk("R7 follow forced low", follow, 0);
        chk("R7 data gated", den, 0);
        carrier = 1'b1;
        idle(8);
        m_cd = 1;
        chk("R7 data_en restored", den, 1);
        acquire("R8 restart aligned");
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule